// File: doc/BRIEF.md
# Wide Register Host Access Bridge

This bridge lets a host with a 32-bit access port reach 128-bit control registers and a 64-bit SRAM. Each wide value is moved as a series of 32-bit words. For reads, the bridge takes a snapshot of the whole register into a read latch, so every word the host reads comes from the same instant. For writes, the bridge gathers the words in one shared collector and updates the target register in a single step once every word has arrived. The register bank repeats once per page. Each page holds normal wide registers and two write-only descriptor-pointer registers. Page 0 also holds a status register whose bits clear when read, and the SRAM window.

The descriptor-pointer registers need no lock on the host side. A write to their top word always commits the register, and any low word the collector does not hold for that register is written as zero. A lower-word write to one of them is dropped if the collector is busy with a different target. The stored descriptor values and a one-cycle commit strobe are brought out as plain pins.

Requests use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. That wait is the only back-pressure. Every accepted read gives exactly one response in the next cycle. The response holds steady until `rsp_ready` takes it. Writes give no response.

Top module: `whb_bridge`

## Requirements
- R1: A byte address splits into a page number (address bits above bit 12) and an offset (bits 12:0), so an item in page p sits at p*0x2000 plus its offset. Normal register r is at offset 16*r, and its word w (0..3, bits 32w+31:32w) is at +4w. The two descriptor registers are at offsets 0x800 and 0x810. The status register is at 0x400 in page 0 only. SRAM entry e is at 0x1000+8e in page 0 only, with its low word at +0 and its high word at +4. Pages at or above NUM_PAGES, and unmapped offsets, read as zero and ignore writes.
- R2: A read of word 0 of a normal register, status register or SRAM entry captures the whole item into the read latch. So does a read of any word of an item other than the one latched last, or any such read when nothing has been latched since reset. The returned word comes from that fresh capture.
- R3: A read of a nonzero word of the item already held in the latch returns the latched word, even if the register has been rewritten since the capture.
- R4: Words written to a normal register, in any order, are held in the collector. The register changes only when all four words are held, and then all 128 bits change at once.
- R5: A write to a normal register or SRAM entry that is not the collector's current target throws away the collector's partial data and starts collecting for the new target.
- R6: An SRAM entry uses the same latch and collector with two words. It commits once both its words are held.
- R7: The descriptor registers read as zero, and reading them leaves the read latch untouched.
- R8: A write to word 3 of a descriptor register commits it at once. Low words 0..2 come from the collector when it holds them for that register, and are zero otherwise. The collector is cleared only if it was collecting that register. `dptr_stb` bit (2p+i) pulses for one cycle and `dptr_val` bits [128(2p+i)+127 : 128(2p+i)] show the new value from the same cycle.
- R9: A write to word 0, 1 or 2 of a descriptor register is dropped, with the collector unchanged, when the collector holds data for a different target. Otherwise the word is collected.
- R10: Status bits are set by `stat_evt` and stay set until a capture of the status register clears them all. A status read served from the latch clears nothing.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read raises `rsp_valid` in the next cycle. `rsp_rdata` stays stable while `rsp_valid` is high and `rsp_ready` is low. Writes never raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Host takes read data |
| rsp_rdata | output | 32 | Read word |
| stat_evt | input | 32 | Event bits that set status bits |
| dptr_stb | output | NUM_PAGES*2 | One-cycle descriptor commit strobe |
| dptr_val | output | NUM_PAGES*256 | Stored descriptor register values |

## Verification
The bench chases the corners where a wrong design would quietly return stale or mixed data:
- A register rewritten after it was latched. A design that bypasses the latch would return the new word in the middle of a snapshot.
- A partial collection left behind by a switch of target. A design that keeps the old mask would commit a register with words it never received.
- A descriptor top word written on its own, and a low word written while another register is being collected. A wrong design would either keep garbage in the low bits or wipe out the other register's collection.
- Read-to-clear events read from the latch versus freshly captured. These expose a design that clears on every read.
- A stalled response. This shows whether the data moves or a second request slips in.

// File: rtl/whb_pkg.sv
package whb_pkg;
  typedef enum logic [2:0] {K_NONE, K_NORM, K_STAT, K_DPTR, K_SRAM} item_kind_e;

  localparam int          PAGE_SHIFT = 13;
  localparam int          NUM_DPTR   = 2;
  localparam logic [12:0] OFS_STAT   = 13'h0400;
  localparam logic [12:0] OFS_DPTR   = 13'h0800;
  localparam logic [12:0] OFS_SRAM   = 13'h1000;

  function automatic logic [31:0] pick_word(input logic [127:0] v, input logic [1:0] w);
    return v[{w, 5'd0} +: 32];
  endfunction

  function automatic logic [127:0] put_word(input logic [127:0] v, input logic [1:0] w,
                                            input logic [31:0] d);
    logic [127:0] r;
    r = v;
    r[{w, 5'd0} +: 32] = d;
    return r;
  endfunction
endpackage

// File: rtl/whb_decode.sv
module whb_decode
  import whb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_PAGES  = 2,
  parameter int NUM_WIDE   = 4,
  parameter int SRAM_DEPTH = 8,
  parameter int PAGE_W     = 1,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output item_kind_e        kind,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx,
  output logic [1:0]        word,
  output logic [ADDR_W-1:0] tag
);
  localparam int PG_HI_W = ADDR_W - PAGE_SHIFT;

  logic [PG_HI_W-1:0] pg_all;
  logic [12:0]        ofs;
  logic [12:0]        sram_rel;
  logic               unused_lsb;

  assign pg_all     = addr[ADDR_W-1:PAGE_SHIFT];
  assign ofs        = addr[12:0];
  assign sram_rel   = ofs - OFS_SRAM;
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    kind = K_NONE;
    page = pg_all[PAGE_W-1:0];
    idx  = '0;
    word = addr[3:2];
    tag  = {addr[ADDR_W-1:4], 4'b0};
    if (pg_all < PG_HI_W'(NUM_PAGES)) begin
      if (ofs < 13'(NUM_WIDE * 16)) begin
        kind = K_NORM;
        idx  = IDX_W'(ofs[12:4]);
      end else if (ofs[12:4] == OFS_DPTR[12:4]) begin
        kind = K_DPTR;
        idx  = '0;
      end else if (ofs[12:4] == OFS_DPTR[12:4] + 9'd1) begin
        kind = K_DPTR;
        idx  = IDX_W'(1);
      end else if (pg_all == '0 && ofs[12:4] == OFS_STAT[12:4]) begin
        kind = K_STAT;
      end else if (pg_all == '0 && ofs >= OFS_SRAM && ofs < OFS_SRAM + 13'(SRAM_DEPTH * 8)) begin
        kind = K_SRAM;
        idx  = IDX_W'(sram_rel[12:3]);
        word = {1'b0, addr[2]};
        tag  = {addr[ADDR_W-1:3], 3'b0};
      end
    end
  end
endmodule

// File: rtl/whb_collect.sv
module whb_collect
  import whb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  item_kind_e        kind,
  input  logic [1:0]        word,
  input  logic [ADDR_W-1:0] tag,
  input  logic [31:0]       wdata,
  output logic              cmt_valid,
  output logic [127:0]      cmt_data
);
  logic [ADDR_W-1:0] c_tag, n_tag;
  logic [3:0]        c_mask, n_mask;
  logic [127:0]      c_data, n_data;

  logic         same, held, mine;
  logic [3:0]   full, grow_mask;
  logic [127:0] grow_data;

  assign same = (c_tag == tag);
  assign held = (c_mask != 4'b0);
  assign mine = same && held;
  assign full = (kind == K_SRAM) ? 4'b0011 : 4'b1111;
  assign grow_mask = (mine ? c_mask : 4'b0) | (4'b0001 << word);
  assign grow_data = put_word(mine ? c_data : 128'b0, word, wdata);

  always_comb begin
    n_tag     = c_tag;
    n_mask    = c_mask;
    n_data    = c_data;
    cmt_valid = 1'b0;
    cmt_data  = grow_data;
    if (wr_fire) begin
      unique case (kind)
        K_NORM, K_SRAM: begin
          if ((grow_mask & full) == full) begin
            cmt_valid = 1'b1;
            n_mask    = 4'b0;
          end else begin
            n_tag  = tag;
            n_mask = grow_mask;
            n_data = grow_data;
          end
        end
        K_DPTR: begin
          if (word == 2'd3) begin
            cmt_valid = 1'b1;
            cmt_data  = {wdata, mine ? c_data[95:0] : 96'b0};
            if (mine) n_mask = 4'b0;
          end else if (!(held && !same)) begin
            n_tag  = tag;
            n_mask = grow_mask;
            n_data = grow_data;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_tag  <= '0;
      c_mask <= 4'b0;
      c_data <= '0;
    end else begin
      c_tag  <= n_tag;
      c_mask <= n_mask;
      c_data <= n_data;
    end
  end
endmodule

// File: rtl/whb_rd_latch.sv
module whb_rd_latch
  import whb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  item_kind_e        kind,
  input  logic [1:0]        word,
  input  logic [ADDR_W-1:0] tag,
  input  logic [127:0]      live,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              stat_clr
);
  logic              l_valid;
  logic [ADDR_W-1:0] l_tag;
  logic [127:0]      l_data;
  logic              snap_kind, capture;
  logic [31:0]       rd_word;

  assign snap_kind = (kind == K_NORM) || (kind == K_STAT) || (kind == K_SRAM);
  assign capture   = rd_fire && snap_kind && (!l_valid || l_tag != tag || word == 2'd0);
  assign stat_clr  = capture && (kind == K_STAT);

  always_comb begin
    if (!snap_kind)   rd_word = 32'b0;
    else if (capture) rd_word = pick_word(live, word);
    else              rd_word = pick_word(l_data, word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_valid   <= 1'b0;
      l_tag     <= '0;
      l_data    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (capture) begin
        l_valid <= 1'b1;
        l_tag   <= tag;
        l_data  <= live;
      end
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_word;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/whb_store.sv
module whb_store
  import whb_pkg::*;
#(
  parameter int NUM_PAGES  = 2,
  parameter int NUM_WIDE   = 4,
  parameter int SRAM_DEPTH = 8,
  parameter int PAGE_W     = 1,
  parameter int IDX_W      = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmt_valid,
  input  item_kind_e                        cmt_kind,
  input  logic [PAGE_W-1:0]                 cmt_page,
  input  logic [IDX_W-1:0]                  cmt_idx,
  input  logic [127:0]                      cmt_data,
  input  item_kind_e                        rd_kind,
  input  logic [PAGE_W-1:0]                 rd_page,
  input  logic [IDX_W-1:0]                  rd_idx,
  output logic [127:0]                      rd_live,
  input  logic                              stat_clr,
  input  logic [31:0]                       stat_evt,
  output logic [NUM_PAGES*NUM_DPTR-1:0]     dptr_stb,
  output logic [NUM_PAGES*NUM_DPTR*128-1:0] dptr_val
);
  localparam int N_NORM = NUM_PAGES * NUM_WIDE;

  logic [N_NORM-1:0][127:0]    norm_rd;
  logic [SRAM_DEPTH-1:0][63:0] sram_rd;
  logic [31:0]                 stat_q;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar r = 0; r < NUM_WIDE; r++) begin : g_norm
      logic [127:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (cmt_valid && cmt_kind == K_NORM && cmt_page == PAGE_W'(p) && cmt_idx == IDX_W'(r))
          q <= cmt_data;
      end
      assign norm_rd[p*NUM_WIDE+r] =
        (rd_page == PAGE_W'(p) && rd_idx == IDX_W'(r)) ? q : 128'b0;
    end
    for (genvar d = 0; d < NUM_DPTR; d++) begin : g_dptr
      logic [127:0] q;
      logic         hit;
      assign hit = cmt_valid && cmt_kind == K_DPTR && cmt_page == PAGE_W'(p) && cmt_idx == IDX_W'(d);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q                       <= '0;
          dptr_stb[p*NUM_DPTR+d]  <= 1'b0;
        end else begin
          dptr_stb[p*NUM_DPTR+d] <= hit;
          if (hit) q <= cmt_data;
        end
      end
      assign dptr_val[(p*NUM_DPTR+d)*128 +: 128] = q;
    end
  end

  for (genvar e = 0; e < SRAM_DEPTH; e++) begin : g_sram
    logic [63:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (cmt_valid && cmt_kind == K_SRAM && cmt_idx == IDX_W'(e)) q <= cmt_data[63:0];
    end
    assign sram_rd[e] = (rd_idx == IDX_W'(e)) ? q : 64'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_clr ? 32'b0 : stat_q) | stat_evt;
  end

  always_comb begin
    rd_live = '0;
    unique case (rd_kind)
      K_NORM: for (int k = 0; k < N_NORM; k++) rd_live = rd_live | norm_rd[k];
      K_SRAM: for (int k = 0; k < SRAM_DEPTH; k++) rd_live = rd_live | {64'b0, sram_rd[k]};
      K_STAT: rd_live = {96'b0, stat_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/whb_bridge.sv
module whb_bridge
  import whb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_PAGES  = 2,
  parameter int NUM_WIDE   = 4,
  parameter int SRAM_DEPTH = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [31:0]                       req_wdata,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [31:0]                       rsp_rdata,
  input  logic [31:0]                       stat_evt,
  output logic [NUM_PAGES*NUM_DPTR-1:0]     dptr_stb,
  output logic [NUM_PAGES*NUM_DPTR*128-1:0] dptr_val
);
  localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam int IW_A   = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;
  localparam int IW_B   = (SRAM_DEPTH > 1) ? $clog2(SRAM_DEPTH) : 1;
  localparam int IDX_W  = (IW_A > IW_B) ? IW_A : IW_B;

  item_kind_e        kind;
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        word;
  logic [ADDR_W-1:0] tag;
  logic              fire, rd_fire, wr_fire;
  logic              cmt_valid, stat_clr;
  logic [127:0]      cmt_data, live;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_write;
  assign wr_fire   = fire && req_write;

  whb_decode #(
    .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE),
    .SRAM_DEPTH(SRAM_DEPTH), .PAGE_W(PAGE_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(req_addr), .kind(kind), .page(page), .idx(idx), .word(word), .tag(tag)
  );

  whb_collect #(.ADDR_W(ADDR_W)) u_col (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .kind(kind), .word(word),
    .tag(tag), .wdata(req_wdata), .cmt_valid(cmt_valid), .cmt_data(cmt_data)
  );

  whb_rd_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .kind(kind), .word(word),
    .tag(tag), .live(live), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .stat_clr(stat_clr)
  );

  whb_store #(
    .NUM_PAGES(NUM_PAGES), .NUM_WIDE(NUM_WIDE), .SRAM_DEPTH(SRAM_DEPTH),
    .PAGE_W(PAGE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .cmt_valid(cmt_valid), .cmt_kind(kind), .cmt_page(page), .cmt_idx(idx), .cmt_data(cmt_data),
    .rd_kind(kind), .rd_page(page), .rd_idx(idx), .rd_live(live),
    .stat_clr(stat_clr), .stat_evt(stat_evt),
    .dptr_stb(dptr_stb), .dptr_val(dptr_val)
  );
endmodule

// File: rtl/whb_bridge_chk.sv
module whb_bridge_chk #(
  parameter int NUM_PAGES = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [31:0]                rsp_rdata,
  input logic [NUM_PAGES*2-1:0]     dptr_stb,
  input logic [NUM_PAGES*256-1:0]   dptr_val
);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R11
  req_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // R11
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));

  // R8
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dptr_stb));

  // R8
  stb_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dptr_stb != '0) |-> $past(req_valid && req_ready && req_write));

  // R8
  dptr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dptr_val != $past(dptr_val)) |-> (dptr_stb != '0));
endmodule

bind whb_bridge whb_bridge_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .dptr_stb(dptr_stb), .dptr_val(dptr_val)
);

// File: tb/sim_whb_bridge.sv
`timescale 1ns/1ps
module sim_whb_bridge;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [15:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0, stat_evt = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [3:0]   dptr_stb;
  logic [511:0] dptr_val;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  whb_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .stat_evt(stat_evt), .dptr_stb(dptr_stb), .dptr_val(dptr_val)
  );

  // reference state
  logic [127:0] m_norm [2][4];
  logic [127:0] m_dptr [2][2];
  logic [63:0]  m_sram [8];
  logic [31:0]  m_stat;
  logic [15:0]  c_tag;  logic [3:0] c_mask;  logic [127:0] c_data;
  bit           l_valid; logic [15:0] l_tag; logic [127:0] l_data;
  int           exp_stb;

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void dec(input logic [15:0] a, output int k, output int p, output int i,
                              output int w, output logic [15:0] t);
    logic [12:0] o;
    o = a[12:0];
    p = int'(a[15:13]); k = 0; i = 0; w = int'(a[3:2]); t = {a[15:4], 4'b0};
    if (p < 2) begin
      if (o < 13'h40) begin k = 1; i = int'(o[12:4]); end
      else if (o[12:4] == 9'h080) begin k = 3; i = 0; end
      else if (o[12:4] == 9'h081) begin k = 3; i = 1; end
      else if (p == 0 && o[12:4] == 9'h040) k = 2;
      else if (p == 0 && o >= 13'h1000 && o < 13'h1040) begin
        k = 4; i = int'(o[5:3]); w = int'(a[2]); t = {a[15:3], 3'b0};
      end
    end
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] d);
    int k, p, i, w; logic [15:0] t; bit mine, held; logic [127:0] base; logic [3:0] bm, full;
    dec(a, k, p, i, w, t);
    exp_stb = -1;
    held = (c_mask != 0); mine = held && (c_tag == t);
    base = mine ? c_data : 128'b0; bm = mine ? c_mask : 4'b0;
    base[w*32 +: 32] = d; bm[w] = 1'b1;
    if (k == 1 || k == 4) begin
      full = (k == 4) ? 4'h3 : 4'hF;
      if ((bm & full) == full) begin
        if (k == 1) m_norm[p][i] = base; else m_sram[i] = base[63:0];
        c_mask = 0;
      end else begin c_tag = t; c_mask = bm; c_data = base; end
    end else if (k == 3) begin
      if (w == 3) begin
        m_dptr[p][i] = {d, mine ? c_data[95:0] : 96'b0};
        exp_stb = p*2 + i;
        if (mine) c_mask = 0;
      end else if (!(held && !mine)) begin c_tag = t; c_mask = bm; c_data = base; end
    end
  endfunction

  function automatic logic [31:0] model_read(input logic [15:0] a);
    int k, p, i, w; logic [15:0] t; logic [127:0] live;
    dec(a, k, p, i, w, t);
    if (k == 1 || k == 2 || k == 4) begin
      if (!l_valid || l_tag != t || w == 0) begin
        live = (k == 1) ? m_norm[p][i] : (k == 4) ? {64'b0, m_sram[i]} : {96'b0, m_stat};
        l_valid = 1; l_tag = t; l_data = live;
        if (k == 2) m_stat = 0;
      end
      return l_data[w*32 +: 32];
    end
    return 32'b0;
  endfunction

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input string req);
    logic [3:0] es; logic [511:0] ev;
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); model_write(a, d);
    @(negedge clk); req_valid = 0;
    es = (exp_stb < 0) ? 4'b0 : (4'b1 << exp_stb);
    for (int q = 0; q < 4; q++) ev[q*128 +: 128] = m_dptr[q/2][q%2];
    check(dptr_stb == es, {req, " strobe"}, 128'(dptr_stb), 128'(es));
    check(dptr_val == ev, {req, " dptr"}, dptr_val[127:0] ^ dptr_val[255:128] ^ dptr_val[383:256] ^ dptr_val[511:384],
          ev[127:0] ^ ev[255:128] ^ ev[383:256] ^ ev[511:384]);
    check(!rsp_valid, "R11 no write response", 128'(rsp_valid), 128'(0));
  endtask

  task automatic bus_read(input logic [15:0] a, input string req);
    logic [31:0] e;
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); e = model_read(a);
    @(negedge clk); req_valid = 0;
    check(rsp_valid && rsp_rdata == e, req, {rsp_valid, 32'b0, rsp_rdata}, {1'b1, 32'b0, e});
  endtask

  task automatic pulse_evt(input logic [31:0] v);
    @(negedge clk); stat_evt = v;
    @(negedge clk); stat_evt = 0; m_stat |= v;
  endtask

  function automatic logic [15:0] A(input int pg, input int ofs);
    return {3'(pg), 13'(ofs)};
  endfunction

  function automatic logic [15:0] rand_addr();
    int c; c = int'($urandom_range(0, 9));
    case (c)
      0, 1, 2, 3: return A($urandom_range(0,1), $urandom_range(0,3)*16 + $urandom_range(0,3)*4);
      4: return A($urandom_range(0,1), 'h800 + $urandom_range(0,1)*16 + ($urandom_range(0,1) ? 12 : $urandom_range(0,3)*4));
      5, 6: return A(0, 'h1000 + $urandom_range(0,3)*8 + $urandom_range(0,1)*4);
      7: return A(0, 'h400 + $urandom_range(0,3)*4);
      8: return A(2, $urandom_range(0,3)*16);
      default: return A(0, 'h200);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held_d;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 2; p++) for (int r = 0; r < 4; r++) m_norm[p][r] = 0;
    for (int p = 0; p < 2; p++) for (int r = 0; r < 2; r++) m_dptr[p][r] = 0;
    for (int e = 0; e < 8; e++) m_sram[e] = 0;
    m_stat = 0; c_tag = 0; c_mask = 0; c_data = 0; l_valid = 0; l_tag = 0; l_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11 reset handshake", {rsp_valid, req_ready}, 128'b01);
    check(dptr_stb == 0 && dptr_val == 0, "R8 reset dptr", 128'(dptr_stb), 0);
    rst_n = 1;

    // R4 partial then complete, out of order
    bus_write(A(0,'h18), 32'h2222_0002, "R4");
    bus_write(A(0,'h10), 32'h0000_0010, "R4");
    bus_write(A(0,'h14), 32'h1111_0001, "R4");
    bus_read(A(0,'h10), "R4 unchanged before full");
    bus_write(A(0,'h1C), 32'h3333_0003, "R4");
    for (int w = 0; w < 4; w++) bus_read(A(0, 'h10 + 4*w), "R4 committed");
    // R2/R3 snapshot against a rewrite
    bus_read(A(0,'h10), "R2 capture");
    for (int w = 0; w < 4; w++) bus_write(A(0, 'h10 + 4*w), 32'hA0A0_0000 + w, "R4");
    bus_read(A(0,'h18), "R3 latched word");
    bus_read(A(0,'h10), "R2 recapture");
    bus_read(A(0,'h18), "R2 fresh word");
    // R5 target switch
    bus_write(A(0,'h20), 32'hDEAD_0000, "R5");
    for (int w = 0; w < 4; w++) bus_write(A(1, 'h20 + 4*w), 32'h5A00_0000 + w, "R5");
    for (int w = 1; w < 4; w++) bus_write(A(0, 'h20 + 4*w), 32'hBEEF_0000 + w, "R5");
    bus_read(A(0,'h2C), "R5 no commit");
    bus_read(A(1,'h24), "R1 page 1");
    // R1 invalid page and unmapped
    for (int w = 0; w < 4; w++) bus_write(A(2, 'h20 + 4*w), 32'h7777_0000 + w, "R1");
    bus_read(A(2,'h20), "R1 bad page");
    bus_read(A(1,'h20), "R1 page 1 untouched");
    bus_write(A(0,'h200), 32'h1, "R1"); bus_read(A(0,'h200), "R1 unmapped");
    // R6 SRAM
    bus_write(A(0,'h1018), 32'hC0DE_0001, "R6");
    bus_read(A(0,'h1018), "R6 partial");
    bus_write(A(0,'h101C), 32'hC0DE_0002, "R6");
    bus_read(A(0,'h1018), "R6 low"); bus_read(A(0,'h101C), "R6 high");
    // R7 descriptor reads
    bus_read(A(0,'h30), "R2 capture");
    bus_read(A(0,'h804), "R7 reads zero");
    bus_read(A(0,'h34), "R7 latch kept");
    // R8 top-word commit with zero fill
    bus_write(A(1,'h804), 32'h0101_0101, "R8");
    bus_write(A(1,'h80C), 32'hF0F0_F0F0, "R8 commit");
    bus_write(A(0,'h81C), 32'h1234_5678, "R8 alone");
    // R9 drop while collecting another target
    bus_write(A(0,'h30), 32'h3000_0000, "R9");
    bus_write(A(0,'h804), 32'hBAD0_0001, "R9 dropped");
    bus_write(A(0,'h34), 32'h3000_0001, "R9");
    bus_write(A(0,'h38), 32'h3000_0002, "R9");
    bus_write(A(0,'h3C), 32'h3000_0003, "R9");
    bus_read(A(0,'h30), "R9 other kept"); bus_read(A(0,'h34), "R9 other kept");
    bus_write(A(0,'h80C), 32'h0C0C_0C0C, "R9 no stale low");
    bus_write(A(0,'h00), 32'h0000_00AA, "R8");
    bus_write(A(1,'h81C), 32'h9999_9999, "R8 foreign collector");
    bus_write(A(0,'h04), 32'h0000_00BB, "R8");
    bus_write(A(0,'h08), 32'h0000_00CC, "R8");
    bus_write(A(0,'h0C), 32'h0000_00DD, "R8");
    bus_read(A(0,'h00), "R8 collector survived"); bus_read(A(0,'h04), "R8 collector survived");
    // R10 read-to-clear
    pulse_evt(32'h5);
    bus_read(A(0,'h400), "R10 capture");
    bus_read(A(0,'h400), "R10 cleared");
    pulse_evt(32'h8);
    bus_read(A(0,'h400), "R10 capture");
    pulse_evt(32'h2);
    bus_read(A(0,'h404), "R10 latch no clear");
    bus_read(A(0,'h400), "R10 kept");
    // R11 stall
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = A(0,'h1018);
    @(posedge clk); held_d = model_read(A(0,'h1018));
    @(negedge clk); req_valid = 0;
    check(rsp_valid && rsp_rdata == held_d, "R11 stalled data", 128'(rsp_rdata), 128'(held_d));
    check(!req_ready, "R11 ready low", 128'(req_ready), 0);
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_rdata == held_d, "R11 held", 128'(rsp_rdata), 128'(held_d));
    rsp_ready = 1;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11 drained", 128'(rsp_valid), 0);
    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [15:0] a;
      a = rand_addr();
      if ($urandom_range(0,1) == 1) bus_write(a, $urandom(), "R4/R8 random");
      else bus_read(a, "R2/R3 random");
    end
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule